// File: doc/BRIEF.md
# Smart Card Slot Power Sequencer

This block brings one smart card slot up and down under control of a host. The host pulls an active-low session request to start a card session. The block then switches the card supply on, enables the card data line, starts the card clock and finally hands the card reset line to the host. All of these steps fall at fixed points measured in a time unit T. T is a parameterised number of clock cycles; one T is 64 cycles of the internal oscillator when the default of two halves of 32 is used. Releasing the request runs the reverse order. A detected fault runs the same reverse order on its own and flags the fault to the host.

The host chooses the card supply level with two select pins, and the 1.8 V select wins over the 5 V/3 V select. The level is captured when a session starts. When both selects are high while the slot is idle and no session is requested, the slot enters a low-power stop state. The slot stays dark until the supply-good flag has been high for a fixed settling time. The same wait starts again after leaving stop. The regulator, the level shifters and the clock divider are outside the block and appear only as enable, level and ready signals.

Top module: `card_slot_seq`

## Requirements
- R1: After reset every output is low. A session request is ignored until `supply_ok` has been high for POR_CYC consecutive cycles.
- R2: An accepted request raises `vcc_en` within two cycles. `io_en` stays low until 4T after the start and rises within a few cycles after that point.
- R3: When `host_rst` is low at the moment the request is accepted, `clk_en` rises together with `io_en` at 4T.
- R4: When `host_rst` is high at acceptance, the clock starts when `host_rst` falls, but never before 4T. If `host_rst` has not fallen by 7T, the clock stays off for the whole session and a later fall of `host_rst` has no effect.
- R5: `card_rst` is low until 7T. After that it follows `host_rst` with one cycle of delay.
- R6: When the request returns high, `card_rst` falls at once, `clk_en` falls at T/2, `io_en` falls at T and `vcc_en` falls at 1.5T. The slot counts as idle again only once `vcc_ready` is low.
- R7: Overcurrent, overtemperature, a regulator error or card removal during a session raises `fault` and runs the R6 order. `fault` stays high until the request is high and the slot is idle.
- R8: If `vcc_ready` is not high by 1.5T after activation starts, or drops later in the session, the block treats this as a fault as in R7.
- R9: `vcc_level` is 2'b10 (1.8 V) when `sel_18v` is high, otherwise 2'b01 (5 V) when `sel_5v` is high, otherwise 2'b00 (3 V). It is sampled when a session starts and held while the supply is on.
- R10: With both selects high and the request high, an idle slot enters stop and `stop_mode` goes high. A shutdown already in progress finishes first. Leaving stop restarts the R1 settling wait.
- R11: A request made while no card is present is ignored. The request must go high again before a new activation is accepted.
- R12: `supply_ok` falling during a session raises `fault` and runs the R6 order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Session request, active low |
| host_rst | input | 1 | Host reset line for the card |
| sel_18v | input | 1 | 1.8 V select, has priority |
| sel_5v | input | 1 | 5 V (high) or 3 V (low) select |
| card_present | input | 1 | Card is in the slot (already debounced) |
| flt_overcurrent | input | 1 | Supply overcurrent detected |
| flt_overtemp | input | 1 | Overtemperature detected |
| flt_regulator | input | 1 | Regulator out of range |
| supply_ok | input | 1 | Host supply above its threshold |
| vcc_ready | input | 1 | Regulator reports card supply up |
| vcc_en | output | 1 | Card supply enable |
| vcc_level | output | 2 | Card supply level code |
| io_en | output | 1 | Card data line enable |
| card_rst | output | 1 | Card reset contact |
| clk_en | output | 1 | Card clock enable |
| fault | output | 1 | Fault indication to host |
| stop_mode | output | 1 | Slot in low-power stop |

## Verification
A wrong state or half-T count shows up as an output edge in the wrong window. The data line or clock would come on early or late against 4T, or the reset would be released before 7T. Each such error is visible within one half-T of the intended edge. A lost arming or fault latch shows up as a second activation with no release of the request, or as `fault` clearing while the request is still low. An error in the shutdown order breaks the enable nesting (clock, then data line, then supply) on the very cycle it happens.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_ON,
    ST_DEACT,
    ST_STOP
  } seq_st_t;

  localparam int HALF_W = 5;
  typedef logic [HALF_W-1:0] half_t;

  // activation points, in halves of T from the start of activation
  localparam half_t H_RAMP = 5'd3;   // supply must be up (1.5T)
  localparam half_t H_IO   = 5'd8;   // data line enabled (4T)
  localparam half_t H_RST  = 5'd14;  // reset handed to host (7T)
  // shutdown points, in halves of T from the start of shutdown
  localparam half_t H_CLKOFF = 5'd1;
  localparam half_t H_IOOFF  = 5'd2;
  localparam half_t H_VOFF   = 5'd3;

  localparam logic [1:0] LVL_3V  = 2'b00;
  localparam logic [1:0] LVL_5V  = 2'b01;
  localparam logic [1:0] LVL_18V = 2'b10;

  function automatic logic [1:0] pick_level(input logic s18, input logic s5);
    if (s18)     return LVL_18V;
    else if (s5) return LVL_5V;
    else         return LVL_3V;
  endfunction

endpackage

// File: rtl/card_seq_tick.sv
module card_seq_tick import card_seq_pkg::*; #(
  parameter int HALF_T_CYC = 32
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  output half_t half
);
  localparam int CW = (HALF_T_CYC > 1) ? $clog2(HALF_T_CYC) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(HALF_T_CYC - 1);
  localparam half_t HALF_MAX = '1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      half <= '0;
    end else if (cnt == CNT_MAX) begin
      cnt <= '0;
      if (half != HALF_MAX) half <= half + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/card_seq_por.sv
module card_seq_por #(
  parameter int POR_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic restart,
  output logic por_ok
);
  localparam int PW = $clog2(POR_CYC + 1);
  localparam logic [PW-1:0] PMAX = PW'(POR_CYC);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart || !supply_ok) begin
      cnt    <= '0;
      por_ok <= 1'b0;
    end else if (cnt == PMAX) begin
      por_ok <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/card_seq_fsm.sv
module card_seq_fsm import card_seq_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  half_t      half,
  input  logic       por_ok,
  input  logic       req_n,
  input  logic       host_rst,
  input  logic       sel_18v,
  input  logic       sel_5v,
  input  logic       card_present,
  input  logic       flt_any,
  input  logic       vcc_ready,
  output logic       tick_clr,
  output logic       por_restart,
  output logic       vcc_en,
  output logic [1:0] vcc_level,
  output logic       io_en,
  output logic       card_rst,
  output logic       clk_en,
  output logic       fault,
  output logic       stop_mode
);
  seq_st_t st, nxt;
  logic armed, wait_drop;
  logic stop_req, in_sess, ramp_bad, sess_flt;

  always_comb begin
    stop_req = sel_18v & sel_5v & req_n;
    in_sess  = (st == ST_ACT) || (st == ST_ON);
    ramp_bad = !vcc_ready && ((st == ST_ON) || (half >= H_RAMP));
    sess_flt = in_sess && (flt_any || !card_present || !por_ok || ramp_bad);
    nxt = st;
    case (st)
      ST_IDLE: begin
        if (stop_req) nxt = ST_STOP;
        else if (!req_n && armed && card_present && por_ok) nxt = ST_ACT;
      end
      ST_ACT: begin
        if (req_n || sess_flt) nxt = ST_DEACT;
        else if (half >= H_RST) nxt = ST_ON;
      end
      ST_ON:    if (req_n || sess_flt) nxt = ST_DEACT;
      ST_DEACT: if (half >= H_VOFF && !vcc_ready) nxt = ST_IDLE;
      ST_STOP:  if (!stop_req) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    tick_clr    = (nxt != st);
    por_restart = (st == ST_STOP) && (nxt == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      armed     <= 1'b0;
      wait_drop <= 1'b0;
      vcc_level <= LVL_3V;
      vcc_en    <= 1'b0;
      io_en     <= 1'b0;
      clk_en    <= 1'b0;
      card_rst  <= 1'b0;
      fault     <= 1'b0;
      stop_mode <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE && !req_n) armed <= 1'b0;
      else if (req_n)              armed <= 1'b1;
      if (st == ST_IDLE && nxt == ST_ACT) begin
        wait_drop <= host_rst;
        vcc_level <= pick_level(sel_18v, sel_5v);
      end
      if (sess_flt)                  fault <= 1'b1;
      else if (st == ST_IDLE && req_n) fault <= 1'b0;
      stop_mode <= (st == ST_STOP);
      case (st)
        ST_ACT: begin
          vcc_en   <= 1'b1;
          io_en    <= (half >= H_IO);
          clk_en   <= clk_en || ((half >= H_IO) && (!wait_drop || !host_rst));
          card_rst <= 1'b0;
        end
        ST_ON: begin
          vcc_en   <= 1'b1;
          io_en    <= 1'b1;
          card_rst <= host_rst;
        end
        ST_DEACT: begin
          vcc_en   <= vcc_en && (half < H_VOFF);
          io_en    <= io_en  && (half < H_IOOFF);
          clk_en   <= clk_en && (half < H_CLKOFF);
          card_rst <= 1'b0;
        end
        default: begin
          vcc_en   <= 1'b0;
          io_en    <= 1'b0;
          clk_en   <= 1'b0;
          card_rst <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/card_slot_seq.sv
module card_slot_seq import card_seq_pkg::*; #(
  parameter int HALF_T_CYC = 32,
  parameter int POR_CYC    = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_n,
  input  logic       host_rst,
  input  logic       sel_18v,
  input  logic       sel_5v,
  input  logic       card_present,
  input  logic       flt_overcurrent,
  input  logic       flt_overtemp,
  input  logic       flt_regulator,
  input  logic       supply_ok,
  input  logic       vcc_ready,
  output logic       vcc_en,
  output logic [1:0] vcc_level,
  output logic       io_en,
  output logic       card_rst,
  output logic       clk_en,
  output logic       fault,
  output logic       stop_mode
);
  half_t half;
  logic  tick_clr, por_restart, por_ok, flt_any;

  assign flt_any = flt_overcurrent | flt_overtemp | flt_regulator;

  card_seq_tick #(.HALF_T_CYC(HALF_T_CYC)) u_tick (
    .clk(clk), .rst(rst), .clr(tick_clr), .half(half)
  );

  card_seq_por #(.POR_CYC(POR_CYC)) u_por (
    .clk(clk), .rst(rst), .supply_ok(supply_ok),
    .restart(por_restart), .por_ok(por_ok)
  );

  card_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .half(half), .por_ok(por_ok),
    .req_n(req_n), .host_rst(host_rst), .sel_18v(sel_18v), .sel_5v(sel_5v),
    .card_present(card_present), .flt_any(flt_any), .vcc_ready(vcc_ready),
    .tick_clr(tick_clr), .por_restart(por_restart),
    .vcc_en(vcc_en), .vcc_level(vcc_level), .io_en(io_en),
    .card_rst(card_rst), .clk_en(clk_en), .fault(fault), .stop_mode(stop_mode)
  );
endmodule

// File: rtl/card_slot_seq_chk.sv
module card_slot_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       vcc_en,
  input logic [1:0] vcc_level,
  input logic       io_en,
  input logic       card_rst,
  input logic       clk_en,
  input logic       fault,
  input logic       stop_mode
);
  assert_reset_dark_R1: assert property (@(posedge clk)
    rst |=> (!vcc_en && !io_en && !clk_en && !fault && !stop_mode));

  assert_io_under_vcc_R2: assert property (@(posedge clk) disable iff (rst)
    io_en |-> vcc_en);

  assert_clk_under_io_R3: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> io_en);

  assert_rst_under_io_R5: assert property (@(posedge clk) disable iff (rst)
    card_rst |-> io_en);

  assert_fault_drops_rst_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |=> !card_rst);

  assert_level_held_R9: assert property (@(posedge clk) disable iff (rst)
    (vcc_en && $past(vcc_en)) |-> $stable(vcc_level));

  assert_stop_unpowered_R10: assert property (@(posedge clk) disable iff (rst)
    stop_mode |-> (!vcc_en && !io_en && !clk_en));
endmodule

bind card_slot_seq card_slot_seq_chk u_chk (
  .clk(clk), .rst(rst), .vcc_en(vcc_en), .vcc_level(vcc_level),
  .io_en(io_en), .card_rst(card_rst), .clk_en(clk_en),
  .fault(fault), .stop_mode(stop_mode)
);

// File: tb/sim_card_slot_seq.sv
`timescale 1ns/1ps
module sim_card_slot_seq;
  localparam int HT  = 4;
  localparam int POR = 20;

  logic clk = 1'b0;
  logic rst, req_n, host_rst, sel_18v, sel_5v, card_present;
  logic flt_oc, flt_ot, flt_rg, supply_ok, vcc_ready;
  logic vcc_en, io_en, card_rst, clk_en, fault, stop_mode;
  logic [1:0] vcc_level;
  logic reg_block, rdy_d1;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  card_slot_seq #(.HALF_T_CYC(HT), .POR_CYC(POR)) u0 (
    .clk(clk), .rst(rst), .req_n(req_n), .host_rst(host_rst),
    .sel_18v(sel_18v), .sel_5v(sel_5v), .card_present(card_present),
    .flt_overcurrent(flt_oc), .flt_overtemp(flt_ot), .flt_regulator(flt_rg),
    .supply_ok(supply_ok), .vcc_ready(vcc_ready),
    .vcc_en(vcc_en), .vcc_level(vcc_level), .io_en(io_en),
    .card_rst(card_rst), .clk_en(clk_en), .fault(fault), .stop_mode(stop_mode)
  );

  // regulator model: ready follows enable two cycles later
  initial begin
    rdy_d1 = 1'b0; vcc_ready = 1'b0;
    forever begin
      @(negedge clk);
      vcc_ready = rdy_d1 & ~reg_block;
      rdy_d1 = vcc_en;
    end
  end

  function automatic logic [1:0] exp_level(input bit s18, input bit s5);
    return s18 ? 2'b10 : (s5 ? 2'b01 : 2'b00);
  endfunction

  // clock expected on after 4T (t=38) or after 7T (t=60)
  function automatic bit exp_clk(input bit rin, input int drop, input int limit);
    return !rin || (drop > 0 && drop <= limit);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit clk_at60;

  task automatic run_act(input bit s18, input bit s5, input bit rin, input int drop);
    sel_18v = s18; sel_5v = s5; host_rst = rin; req_n = 1'b0;
    for (int t = 1; t <= 60; t++) begin
      step(1);
      if (t == drop) host_rst = 1'b0;
      if (t == 2) begin
        chk("R2 vcc_en on", vcc_en, 1);
        chk("R9 level", vcc_level, exp_level(s18, s5));
      end
      if (t == 33) begin
        chk("R2 io_en early", io_en, 0);
        chk("R3 clk early", clk_en, 0);
      end
      if (t == 38) begin
        chk("R2 io_en at 4T", io_en, 1);
        chk("R4 clk at 4T", clk_en, exp_clk(rin, drop, 35));
      end
      if (t == 50) chk("R5 reset held", card_rst, 0);
    end
    clk_at60 = exp_clk(rin, drop, 53);
    chk("R4 clk after 7T", clk_en, clk_at60);
    chk("R5 reset follows", card_rst, host_rst);
    chk("R9 level held", vcc_level, exp_level(s18, s5));
    if (host_rst) begin
      step(1); host_rst = 1'b0; step(4);
      chk("R4 late drop no clock", clk_en, clk_at60);
      chk("R5 reset follows low", card_rst, 0);
    end
  endtask

  task automatic run_deact(input bit expect_stop);
    req_n = 1'b1;
    step(3);
    chk("R6 reset low", card_rst, 0);
    chk("R6 clk still on", clk_en, clk_at60);
    step(4);
    chk("R6 clk off", clk_en, 0);
    chk("R6 io still on", io_en, 1);
    step(4);
    chk("R6 io off", io_en, 0);
    chk("R6 vcc still on", vcc_en, 1);
    step(4);
    chk("R6 vcc off", vcc_en, 0);
    step(10);
    chk("R10 stop after shutdown", stop_mode, expect_stop);
    sel_18v = 1'b0; sel_5v = 1'b0;
    step(POR + 5);
  endtask

  initial begin
    rst = 1; req_n = 1; host_rst = 0; sel_18v = 0; sel_5v = 0;
    card_present = 1; flt_oc = 0; flt_ot = 0; flt_rg = 0;
    supply_ok = 1; reg_block = 0;
    void'($urandom(32'd7013));
    step(3); rst = 0; step(1);
    chk("R1 vcc after reset", vcc_en, 0);
    chk("R1 io after reset", io_en, 0);
    chk("R1 clk after reset", clk_en, 0);
    chk("R1 fault after reset", fault, 0);
    chk("R1 stop after reset", stop_mode, 0);
    step(1); req_n = 0; step(8);
    chk("R1 request before settle", vcc_en, 0);
    req_n = 1; step(POR + 5);

    // plain 5V session, clock with data line
    run_act(0, 1, 0, 0); run_deact(0);
    // both selects high, clock on reset drop, then stop after shutdown
    run_act(1, 1, 1, 42); run_deact(1);
    sel_18v = 1; sel_5v = 1; step(30);
    chk("R10 stop entered", stop_mode, 1);
    sel_5v = 0; step(3);
    chk("R10 stop left", stop_mode, 0);
    req_n = 0; step(10);
    chk("R10 settle wait after stop", vcc_en, 0);
    req_n = 1; sel_18v = 0; step(POR + 5);
    // reset never dropped: no clock
    run_act(0, 0, 1, 0); run_deact(0);

    // regulator never ready
    reg_block = 1; req_n = 0; step(16);
    chk("R8 ramp fault", fault, 1);
    step(20);
    chk("R8 supply off", vcc_en, 0);
    chk("R7 fault held while request low", fault, 1);
    req_n = 1; reg_block = 0; step(3);
    chk("R7 fault cleared", fault, 0);
    step(10);

    // overcurrent in session
    run_act(0, 1, 0, 0);
    flt_oc = 1; step(3);
    chk("R7 overcurrent fault", fault, 1);
    chk("R7 reset dropped", card_rst, 0);
    flt_oc = 0; step(20);
    chk("R7 supply off", vcc_en, 0);
    chk("R7 io off", io_en, 0);
    req_n = 1; step(3);
    chk("R7 fault cleared", fault, 0);
    step(10);

    // supply drop in session
    run_act(1, 0, 0, 0);
    supply_ok = 0; step(4);
    chk("R12 supply fault", fault, 1);
    step(20);
    chk("R12 supply off", vcc_en, 0);
    supply_ok = 1; req_n = 1; step(5);
    req_n = 0; step(5);
    chk("R12 settle wait after drop", vcc_en, 0);
    req_n = 1; step(POR + 5);

    // card removal, then request without card
    run_act(0, 0, 0, 0);
    card_present = 0; step(4);
    chk("R7 removal fault", fault, 1);
    step(20); req_n = 1; step(3);
    req_n = 0; step(8);
    chk("R11 no card ignored", vcc_en, 0);
    card_present = 1; step(8);
    chk("R11 needs rearm", vcc_en, 0);
    req_n = 1; step(2);
    run_act(0, 1, 0, 0); run_deact(0);

    // random sessions
    for (int i = 0; i < 12; i++) begin
      bit s18, s5, rin;
      int drop;
      s18 = 1'($urandom_range(0, 1));
      s5  = 1'($urandom_range(0, 1));
      rin = 1'($urandom_range(0, 1));
      drop = 0;
      if (rin) begin
        case ($urandom_range(0, 2))
          0: drop = 30 + int'($urandom_range(0, 5));
          1: drop = 40 + int'($urandom_range(0, 13));
          default: drop = 0;
        endcase
      end
      run_act(s18, s5, rin, drop);
      run_deact(s18 & s5);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule